// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-page to physical-page translations in front of a page table walker. Each cycle it may accept one lookup carrying a full virtual address. One cycle later it reports whether a translation was present. On a hit it also returns the physical address, made from the cached physical page number with the page offset copied through unchanged. On a miss the walker resolves the page and hands the result to a fill port, which installs it as a new entry.

Two maintenance inputs keep the cache consistent with the page tables. The first drops the single entry for one virtual page, and is used after that page's table entry is rewritten. The second drops every entry, and is used when a new page-directory root is loaded. A mode input selects the victim choice for fills into a full cache: least recently used by timestamp, or a pseudo-random index from a small LFSR.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is low, and the first lookups all report a miss.
- R2: A lookup presented in cycle N gives `rsp_valid` high in cycle N+1, with `rsp_hit` and `rsp_paddr` computed from the cache contents as they stood before any update made at that same edge. On a miss `rsp_paddr` is zero.
- R3: On a hit, `rsp_paddr` holds the cached physical page number in its upper bits and the lowest 12 bits of the lookup address unchanged in its lower 12 bits.
- R4: An accepted fill makes later lookups of its virtual page hit with its physical page. A fill for a virtual page that is already cached rewrites that same entry, so no page is ever held twice.
- R5: A fill for an uncached page goes to the lowest-numbered invalid entry whenever one exists. Replacement applies only when every entry is valid.
- R6: With `repl_mode` = 0 (LRU), each lookup hit and each fill marks its entry most recent. If a hit and a fill land in the same cycle, the fill counts as the later one. A fill into a full cache evicts the least recently marked entry.
- R7: With `repl_mode` = 1 (random), hits leave all state unchanged, and a fill into a full cache evicts the entry whose index equals the LFSR value in that cycle. The LFSR is log2(ENTRIES) bits wide, seeded to 1 at reset and advanced on every clock. Each step shifts toward the MSB and feeds a new LSB. For 8 entries the new LSB is bit2 XOR bit1; for 64 entries it is bit5 XOR bit4.
- R8: Asserting `inv_valid` with `inv_vpn` removes the entry for that page, and later lookups of it miss.
- R9: Asserting `root_load` makes every entry invalid at that edge.
- R10: A fill in the same cycle as `inv_valid` or `root_load` is discarded.
- R11: An invalidate naming a page that is not cached leaves every cached translation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| repl_mode | input | 1 | 0 = LRU victim, 1 = pseudo-random victim |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| rsp_valid | output | 1 | Lookup response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | PPN_W+OFF_W | Translated physical address (zero on miss) |
| fill_valid | input | 1 | Walker result strobe |
| fill_vpn | input | VPN_W | Virtual page number being installed |
| fill_ppn | input | PPN_W | Physical page number being installed |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | VPN_W | Page to invalidate |
| root_load | input | 1 | Page-directory root written; drop all entries |

## Verification
The bench builds the block with ENTRIES = 8 and all other parameters left at their defaults. With eight entries, a few dozen fills are enough to fill the cache, wrap the LFSR several times and cause repeated evictions in both policies. Same-cycle collisions are easy to reach at that size: a hit together with a fill, a fill together with an invalidate, and a fill together with a root load.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic {
    REPL_LRU  = 1'b0,
    REPL_RAND = 1'b1
  } repl_mode_e;

  // Feedback mask for a maximal-length shift register of the given width.
  function automatic logic [7:0] lfsr_mask(input int width);
    case (width)
      3:       lfsr_mask = 8'b0000_0110;
      4:       lfsr_mask = 8'b0000_1100;
      5:       lfsr_mask = 8'b0001_0100;
      6:       lfsr_mask = 8'b0011_0000;
      7:       lfsr_mask = 8'b0110_0000;
      default: lfsr_mask = 8'b1011_1000;
    endcase
  endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value_o
);
  import tlb_pkg::*;

  localparam logic [7:0] MASK8 = lfsr_mask(W);
  localparam logic [W-1:0] MASK = MASK8[W-1:0];

  logic [W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = {lfsr_q[W-2:0], ^(lfsr_q & MASK)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= W'(1);
    else        lfsr_q <= lfsr_d;
  end

  assign value_o = lfsr_q;

  a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 64,
  parameter int SW      = 25,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]         valid_i,
  input  logic [ENTRIES-1:0][SW-1:0] stamp_i,
  input  logic [IW-1:0]              rand_idx_i,
  input  logic                       use_rand_i,
  output logic [IW-1:0]              victim_o
);

  logic [IW-1:0] free_idx;
  logic [IW-1:0] old_idx;
  logic          any_free;

  // Lowest-numbered invalid entry.
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IW'(i);
    end
    any_free = ~&valid_i;
  end

  // Oldest stamp; strict compare keeps the lower index on a tie.
  always_comb begin
    old_idx = '0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (stamp_i[i] < stamp_i[old_idx]) old_idx = IW'(i);
    end
  end

  always_comb begin
    if (any_free)        victim_o = free_idx;
    else if (use_rand_i) victim_o = rand_idx_i;
    else                 victim_o = old_idx;
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int TICK_W  = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   repl_mode,
  input  logic                   lkp_valid,
  input  logic [VPN_W+OFF_W-1:0] lkp_vaddr,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [PPN_W+OFF_W-1:0] rsp_paddr,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   inv_valid,
  input  logic [VPN_W-1:0]       inv_vpn,
  input  logic                   root_load
);
  import tlb_pkg::*;

  localparam int IW = $clog2(ENTRIES);
  localparam int SW = TICK_W + 1;

  repl_mode_e mode_e;
  assign mode_e = repl_mode_e'(repl_mode);

  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q, vpn_d;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q, ppn_d;
  logic [ENTRIES-1:0][SW-1:0]    stamp_q, stamp_d;
  logic [TICK_W-1:0]             tick_q;

  logic [VPN_W-1:0]   lkp_vpn;
  logic [OFF_W-1:0]   lkp_off;
  logic [ENTRIES-1:0] lkp_hit_vec, fill_hit_vec, inv_hit_vec;
  logic [IW-1:0]      lkp_idx, fill_match_idx, victim_idx, fill_idx, rand_idx;
  logic               lkp_hit, fill_en;

  logic               rsp_valid_q, rsp_hit_q;
  logic [PPN_W+OFF_W-1:0] rsp_paddr_q;

  assign lkp_vpn = lkp_vaddr[VPN_W+OFF_W-1:OFF_W];
  assign lkp_off = lkp_vaddr[OFF_W-1:0];

  // Parallel tag compare against every entry, for each of the three ports.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lkp_hit_vec[g]  = valid_q[g] && (vpn_q[g] == lkp_vpn);
    assign fill_hit_vec[g] = valid_q[g] && (vpn_q[g] == fill_vpn);
    assign inv_hit_vec[g]  = valid_q[g] && (vpn_q[g] == inv_vpn);
  end

  always_comb begin
    lkp_idx        = '0;
    fill_match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkp_hit_vec[i])  lkp_idx        = IW'(i);
      if (fill_hit_vec[i]) fill_match_idx = IW'(i);
    end
  end

  assign lkp_hit  = |lkp_hit_vec;
  assign fill_en  = fill_valid && !inv_valid && !root_load;
  assign fill_idx = (|fill_hit_vec) ? fill_match_idx : victim_idx;

  tlb_lfsr #(.W(IW)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .value_o (rand_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .SW(SW)) u_victim (
    .valid_i    (valid_q),
    .stamp_i    (stamp_q),
    .rand_idx_i (rand_idx),
    .use_rand_i (mode_e == REPL_RAND),
    .victim_o   (victim_idx)
  );

  // Next state: hit stamp, then fill, then invalidation/flush.
  always_comb begin
    valid_d = valid_q;
    vpn_d   = vpn_q;
    ppn_d   = ppn_q;
    stamp_d = stamp_q;
    if (lkp_valid && lkp_hit && (mode_e == REPL_LRU)) begin
      stamp_d[lkp_idx] = {tick_q, 1'b0};
    end
    if (fill_en) begin
      valid_d[fill_idx] = 1'b1;
      vpn_d[fill_idx]   = fill_vpn;
      ppn_d[fill_idx]   = fill_ppn;
      stamp_d[fill_idx] = {tick_q, 1'b1};
    end
    if (root_load)      valid_d = '0;
    else if (inv_valid) valid_d = valid_d & ~inv_hit_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= '0;
      tick_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      valid_q     <= valid_d;
      tick_q      <= tick_q + 1'b1;
      rsp_valid_q <= lkp_valid;
      if (lkp_valid) rsp_hit_q <= lkp_hit;
    end
  end

  always_ff @(posedge clk) begin
    vpn_q   <= vpn_d;
    ppn_q   <= ppn_d;
    stamp_q <= stamp_d;
    if (lkp_valid) rsp_paddr_q <= lkp_hit ? {ppn_q[lkp_idx], lkp_off} : '0;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_paddr = rsp_paddr_q;

  a_r4_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lkp_hit_vec));

  a_r5_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(|fill_hit_vec) && !(&valid_q)) |-> !valid_q[victim_idx]);

  a_r8_page_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> ((valid_q & $past(inv_hit_vec)) == '0));

  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    root_load |=> (valid_q == '0));

  a_r10_fill_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && (inv_valid || root_load)) |=>
      ($countones(valid_q) <= $countones($past(valid_q))));

  a_r2_resp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> rsp_valid);

endmodule

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;

  localparam int E = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        repl_mode = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_vaddr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        inv_valid = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic        root_load = 1'b0;

  always #5 clk = ~clk;

  tlb_xlate #(.ENTRIES(E)) dut_i (
    .clk(clk), .rst_n(rst_n), .repl_mode(repl_mode),
    .lkp_valid(lkp_valid), .lkp_vaddr(lkp_vaddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .root_load(root_load)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // Behavioural reference
  bit          m_valid [E];
  logic [19:0] m_vpn   [E];
  logic [19:0] m_ppn   [E];
  int          order[$];        // entry indices, least recent first
  logic [2:0]  m_lfsr;
  bit          exp_valid, exp_hit;
  logic [31:0] exp_paddr;

  function automatic void touch(int idx);
    for (int k = 0; k < order.size(); k++) begin
      if (order[k] == idx) begin order.delete(k); break; end
    end
    order.push_back(idx);
  endfunction

  function automatic void drop(int idx);
    for (int k = 0; k < order.size(); k++) begin
      if (order[k] == idx) begin order.delete(k); break; end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < E; i++) m_valid[i] = 1'b0;
      order.delete();
      m_lfsr    = 3'd1;
      exp_valid = 1'b0;
    end else begin
      int h, f, fr;
      h = -1;
      for (int i = 0; i < E; i++)
        if (m_valid[i] && m_vpn[i] == lkp_vaddr[31:12]) h = i;
      exp_valid = lkp_valid;
      if (lkp_valid) begin
        exp_hit   = (h >= 0);
        exp_paddr = (h >= 0) ? {m_ppn[h], lkp_vaddr[11:0]} : 32'd0;
      end
      if (lkp_valid && h >= 0 && !repl_mode) touch(h);
      if (fill_valid && !inv_valid && !root_load) begin
        f = -1; fr = -1;
        for (int i = 0; i < E; i++)
          if (m_valid[i] && m_vpn[i] == fill_vpn) f = i;
        for (int i = E - 1; i >= 0; i--)
          if (!m_valid[i]) fr = i;
        if (f < 0) f = (fr >= 0) ? fr : (repl_mode ? int'(m_lfsr) : order[0]);
        m_valid[f] = 1'b1; m_vpn[f] = fill_vpn; m_ppn[f] = fill_ppn;
        touch(f);
      end
      if (root_load) begin
        for (int i = 0; i < E; i++) m_valid[i] = 1'b0;
        order.delete();
      end else if (inv_valid) begin
        for (int i = 0; i < E; i++)
          if (m_valid[i] && m_vpn[i] == inv_vpn) begin m_valid[i] = 1'b0; drop(i); end
      end
      m_lfsr = {m_lfsr[1:0], m_lfsr[2] ^ m_lfsr[1]};
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (rsp_valid !== exp_valid) begin
        miscompares++;
        $display("FAIL %s rsp_valid actual=%0b expected=%0b", tag, rsp_valid, exp_valid);
      end else if (exp_valid && (rsp_hit !== exp_hit || rsp_paddr !== exp_paddr)) begin
        miscompares++;
        $display("FAIL %s hit/paddr actual=%0b/%h expected=%0b/%h",
                 tag, rsp_hit, rsp_paddr, exp_hit, exp_paddr);
      end
    end
  end

  task automatic idle_inputs();
    lkp_valid = 0; fill_valid = 0; inv_valid = 0; root_load = 0;
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off);
    @(negedge clk); idle_inputs();
    lkp_valid = 1; lkp_vaddr = {vpn, off};
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn);
    @(negedge clk); idle_inputs();
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn;
  endtask

  task automatic sweep(input logic [11:0] off);
    for (int v = 0; v < 24; v++) lookup(20'h10000 + 20'(v), off + 12'(v * 37));
    @(negedge clk); idle_inputs();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    vectors++;
    if (rsp_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset rsp_valid actual=%0b expected=0", rsp_valid);
    end
    rst_n = 1'b1;
    tag = "R1"; sweep(12'h123);

    tag = "R2"; // and R3, R4: installs and offset pass-through
    fill(20'h10000, 20'hA0001); fill(20'h10001, 20'hA0002); fill(20'h10002, 20'hA0003);
    lookup(20'h10000, 12'h000); lookup(20'h10001, 12'hFFF); lookup(20'h10002, 12'h5A5);
    tag = "R3"; lookup(20'h10001, 12'h001); lookup(20'h1FFFF, 12'h777);
    tag = "R4"; fill(20'h10000, 20'hBEEF0); lookup(20'h10000, 12'h00C); sweep(12'h010);

    tag = "R5"; // fill the rest, then LRU evictions (R6)
    for (int v = 3; v < 8; v++) fill(20'h10000 + 20'(v), 20'hC0000 + 20'(v));
    tag = "R6";
    lookup(20'h10000, 12'h1); lookup(20'h10003, 12'h2); lookup(20'h10001, 12'h3);
    for (int v = 8; v < 11; v++) fill(20'h10000 + 20'(v), 20'hD0000 + 20'(v));
    sweep(12'h020);
    // R6: hit and fill in one cycle
    @(negedge clk); idle_inputs();
    lkp_valid = 1; lkp_vaddr = {20'h10008, 12'h044};
    fill_valid = 1; fill_vpn = 20'h10011; fill_ppn = 20'hE0011;
    fill(20'h10012, 20'hE0012); fill(20'h10013, 20'hE0013);
    sweep(12'h030);

    tag = "R8";
    @(negedge clk); idle_inputs(); inv_valid = 1; inv_vpn = 20'h10012;
    sweep(12'h040);
    tag = "R11";
    @(negedge clk); idle_inputs(); inv_valid = 1; inv_vpn = 20'h1ABCD;
    sweep(12'h050);
    tag = "R5";
    fill(20'h10014, 20'hF0014); fill(20'h10015, 20'hF0015);
    sweep(12'h060);

    tag = "R10";
    @(negedge clk); idle_inputs();
    fill_valid = 1; fill_vpn = 20'h10016; fill_ppn = 20'h11116;
    inv_valid = 1; inv_vpn = 20'h10014;
    sweep(12'h070);
    @(negedge clk); idle_inputs();
    fill_valid = 1; fill_vpn = 20'h10017; fill_ppn = 20'h11117; root_load = 1;
    sweep(12'h080);

    tag = "R9";
    fill(20'h10001, 20'h22221); fill(20'h10002, 20'h22222);
    @(negedge clk); idle_inputs(); root_load = 1;
    sweep(12'h090);

    tag = "R7";
    repl_mode = 1'b1;
    for (int v = 0; v < 20; v++) begin
      fill(20'h10000 + 20'(v), 20'h30000 + 20'(v * 5));
      lookup(20'h10000 + 20'(v / 2), 12'(v));
    end
    sweep(12'h0A0);
    for (int v = 20; v < 24; v++) fill(20'h10000 + 20'(v), 20'h40000 + 20'(v));
    sweep(12'h0B0);
    tag = "R6"; repl_mode = 1'b0;
    for (int v = 0; v < 6; v++) fill(20'h10000 + 20'(v), 20'h50000 + 20'(v));
    sweep(12'h0C0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule